// File: doc/BRIEF.md
# Armed Priority Interrupt Dispatcher

This block decides, once per completed instruction, whether a pending interrupt takes the processor away from what it is running, and if so which level. It looks at four values supplied by the surrounding core: the pending-interrupt word, the arm word (whose top bit is a global enable), the current mode word and the current stack pointer. Only the lowest-numbered pending level is ever a candidate. That candidate is taken only if the block is globally enabled, its own arm bit is set, and the current mode does not outrank the pending word.

When a level is taken, the block reports the level and two table addresses: the vector slot to fetch from, and the slot that receives the current stack pointer. It also reports the pending word with that level cleared and a new one-hot mode word. If a level would be taken but the stack pointer is zero or negative, a halt is raised instead. The core performs the context switch and holds the vector table.

All results are registered. They appear on the cycle after the evaluation strobe and are held until the next strobe.

Top module: `ipd_top`

## Requirements
- R1: After reset, every output is zero: both event pulses, the idle flag, the level, both addresses, the pending word and the mode word.
- R2: A strobe with an all-zero pending word sets the idle flag and raises neither a dispatch nor a halt. The idle flag is low after any strobe with a pending bit set.
- R3: When the top bit of the arm word is clear, no dispatch and no halt is raised, whatever is pending.
- R4: When the mode word has any bit set below its top bit, and the mode word read as a signed number is less than or equal to the pending word read as a signed number, no dispatch and no halt is raised.
- R5: The candidate level is the index of the lowest-numbered set bit of the pending word. Bit 0 is level 0.
- R6: When the arm bit at the candidate's index is clear, no dispatch and no halt is raised, even if higher pending levels are armed.
- R7: On dispatch, the vector address is the table base plus twice the level, and the save address is that value plus one.
- R8: When a dispatch would otherwise occur but the stack pointer, read as signed, is zero or negative, a halt pulse is raised instead. In that case the level, both addresses, the pending word and the mode word keep their earlier values.
- R9: On dispatch, the output pending word equals the input pending word with the taken bit cleared, and the output mode word has only the taken level's bit set. On a strobe with no dispatch, both output words equal their inputs.
- R10: Results appear on the cycle after the strobe. On cycles without a strobe, both pulses are low and every other output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Instruction-complete strobe; evaluate this cycle |
| pend_i | input | LEVELS | Pending-interrupt word |
| arm_i | input | LEVELS | Arm word; top bit is the global enable |
| mode_i | input | LEVELS | Current mode word |
| sp_i | input | ADDR_W | Current stack pointer (signed) |
| dsp_o | output | 1 | Dispatch pulse |
| hlt_o | output | 1 | Halt pulse (no valid stack pointer) |
| idle_o | output | 1 | Nothing was pending at the last strobe |
| lvl_o | output | $clog2(LEVELS) | Level taken at the last dispatch |
| vec_addr_o | output | ADDR_W | Vector slot address |
| save_addr_o | output | ADDR_W | Stack-pointer save slot address |
| pend_o | output | LEVELS | Updated pending word |
| mode_o | output | LEVELS | Updated mode word |

## Verification
With four levels, the bench sweeps every combination of pending, arm and mode words against a positive, a zero and a negative stack pointer. This exercises the signed comparison of mode against pending at every sign pairing. It separates a global disable from a disarmed lowest candidate whose higher neighbours are armed. Zero and negative stack pointers are told apart from a positive one only by the halt pulse. After each evaluation, the bench drives a cycle with no strobe and changed inputs, to show that the outputs hold.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

  typedef enum logic [1:0] {
    DEC_HOLD     = 2'd0,
    DEC_IDLE     = 2'd1,
    DEC_DISPATCH = 2'd2,
    DEC_HALT     = 2'd3
  } ipd_dec_e;

endpackage

// File: rtl/ipd_lsb_find.sv
module ipd_lsb_find #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  first_o
);

  logic [W-1:0] below;

  // below[i] is set when any lower bit is set
  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < W; g++) begin : g_chain
      assign below[g] = below[g-1] | vec_i[g-1];
    end
  endgenerate

  assign first_o = vec_i & ~below;
  assign found_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first_o[i]) idx_o = idx_o | IW'(i);
    end
  end

endmodule

// File: rtl/ipd_gate.sv
module ipd_gate
  import ipd_pkg::*;
#(
  parameter int LEVELS = 32,
  parameter int ADDR_W = 16,
  localparam int LW = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] pend_i,
  input  logic [LEVELS-1:0] arm_i,
  input  logic [LEVELS-1:0] mode_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              cand_vld_i,
  input  logic [LW-1:0]     cand_i,
  output ipd_dec_e          dec_o
);

  logic glob_en;
  logic mode_busy;
  logic mode_outranks;
  logic cand_armed;
  logic sp_ok;

  assign glob_en       = arm_i[LEVELS-1];
  assign mode_busy     = |mode_i[LEVELS-2:0];
  assign mode_outranks = mode_busy && ($signed(mode_i) <= $signed(pend_i));
  assign cand_armed    = arm_i[cand_i];
  assign sp_ok         = !sp_i[ADDR_W-1] && (|sp_i);

  always_comb begin
    if (!cand_vld_i)        dec_o = DEC_IDLE;
    else if (!glob_en)      dec_o = DEC_HOLD;
    else if (mode_outranks) dec_o = DEC_HOLD;
    else if (!cand_armed)   dec_o = DEC_HOLD;
    else if (!sp_ok)        dec_o = DEC_HALT;
    else                    dec_o = DEC_DISPATCH;
  end

endmodule

// File: rtl/ipd_addr.sv
module ipd_addr #(
  parameter int              LEVELS   = 32,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] TBL_BASE = '0,
  localparam int LW = $clog2(LEVELS)
) (
  input  logic [LW-1:0]     lvl_i,
  input  logic [LEVELS-1:0] first_i,
  input  logic [LEVELS-1:0] pend_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic [LEVELS-1:0] pend_clr_o,
  output logic [LEVELS-1:0] mode_oh_o
);

  logic [ADDR_W-1:0] dbl;

  assign dbl         = ADDR_W'({lvl_i, 1'b0});
  assign vec_addr_o  = TBL_BASE + dbl;
  assign save_addr_o = TBL_BASE + (dbl | ADDR_W'(1));
  assign pend_clr_o  = pend_i & ~first_i;
  assign mode_oh_o   = first_i;

endmodule

// File: rtl/ipd_top.sv
module ipd_top
  import ipd_pkg::*;
#(
  parameter int              LEVELS   = 32,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] TBL_BASE = ADDR_W'(64),
  localparam int LW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [LEVELS-1:0] pend_i,
  input  logic [LEVELS-1:0] arm_i,
  input  logic [LEVELS-1:0] mode_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              dsp_o,
  output logic              hlt_o,
  output logic              idle_o,
  output logic [LW-1:0]     lvl_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic [LEVELS-1:0] pend_o,
  output logic [LEVELS-1:0] mode_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // candidate search
  logic              cand_vld;
  logic [LW-1:0]     cand;
  logic [LEVELS-1:0] first;

  ipd_lsb_find #(.W(LEVELS)) u_find (
    .vec_i   (pend_i),
    .found_o (cand_vld),
    .idx_o   (cand),
    .first_o (first)
  );

  // decision
  ipd_dec_e dec;

  ipd_gate #(.LEVELS(LEVELS), .ADDR_W(ADDR_W)) u_gate (
    .pend_i     (pend_i),
    .arm_i      (arm_i),
    .mode_i     (mode_i),
    .sp_i       (sp_i),
    .cand_vld_i (cand_vld),
    .cand_i     (cand),
    .dec_o      (dec)
  );

  // addresses and updated words
  logic [ADDR_W-1:0] vec_c, sav_c;
  logic [LEVELS-1:0] pend_c, mode_c;

  ipd_addr #(.LEVELS(LEVELS), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE)) u_addr (
    .lvl_i       (cand),
    .first_i     (first),
    .pend_i      (pend_i),
    .vec_addr_o  (vec_c),
    .save_addr_o (sav_c),
    .pend_clr_o  (pend_c),
    .mode_oh_o   (mode_c)
  );

  // result registers
  logic              dsp_q, dsp_d;
  logic              hlt_q, hlt_d;
  logic              idle_q, idle_d;
  logic [LW-1:0]     lvl_q, lvl_d;
  logic [ADDR_W-1:0] vec_q, vec_d, sav_q, sav_d;
  logic [LEVELS-1:0] pend_q, pend_d, mode_q, mode_d;
  logic              res_en;
  logic              take;

  assign take = (dec == DEC_DISPATCH);

  always_comb begin
    dsp_d  = 1'b0;
    hlt_d  = 1'b0;
    idle_d = idle_q;
    lvl_d  = lvl_q;
    vec_d  = vec_q;
    sav_d  = sav_q;
    pend_d = pend_q;
    mode_d = mode_q;
    res_en = eval_i;
    if (eval_i) begin
      dsp_d  = take;
      hlt_d  = (dec == DEC_HALT);
      idle_d = (dec == DEC_IDLE);
      if (dec != DEC_HALT) begin
        pend_d = take ? pend_c : pend_i;
        mode_d = take ? mode_c : mode_i;
      end
      if (take) begin
        lvl_d = cand;
        vec_d = vec_c;
        sav_d = sav_c;
      end
    end
  end

  // pulses clear every cycle; held results load only on a strobe
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dsp_q <= 1'b0;
      hlt_q <= 1'b0;
    end else begin
      dsp_q <= dsp_d;
      hlt_q <= hlt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idle_q <= 1'b0;
      lvl_q  <= '0;
      vec_q  <= '0;
      sav_q  <= '0;
      pend_q <= '0;
      mode_q <= '0;
    end else if (res_en) begin
      idle_q <= idle_d;
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
      sav_q  <= sav_d;
      pend_q <= pend_d;
      mode_q <= mode_d;
    end
  end

  assign dsp_o       = dsp_q;
  assign hlt_o       = hlt_q;
  assign idle_o      = idle_q;
  assign lvl_o       = lvl_q;
  assign vec_addr_o  = vec_q;
  assign save_addr_o = sav_q;
  assign pend_o      = pend_q;
  assign mode_o      = mode_q;

endmodule

// File: rtl/ipd_chk.sv
module ipd_chk #(
  parameter int LEVELS = 32,
  parameter int ADDR_W = 16,
  localparam int LW = $clog2(LEVELS)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              eval_i,
  input logic [LEVELS-1:0] pend_i,
  input logic [LEVELS-1:0] arm_i,
  input logic              dsp_o,
  input logic              hlt_o,
  input logic              idle_o,
  input logic [LW-1:0]     lvl_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [ADDR_W-1:0] save_addr_o,
  input logic [LEVELS-1:0] pend_o,
  input logic [LEVELS-1:0] mode_o
);

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dsp_o && hlt_o)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idle_o |-> (!dsp_o && !hlt_o)); // R2

  AST_EVENT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dsp_o || hlt_o) |-> $past(eval_i)); // R10

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !eval_i |=> ($stable(vec_addr_o) && $stable(save_addr_o) && $stable(lvl_o)
                 && $stable(pend_o) && $stable(mode_o) && $stable(idle_o))); // R10

  AST_GLOBAL_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_o |-> $past(arm_i[LEVELS-1])); // R3

  AST_CAND_ARMED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_o |-> ((($past(arm_i) >> lvl_o) & LEVELS'(1)) != '0)); // R6

  AST_LOWEST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_o |-> ((($past(pend_i) << (LEVELS - int'(lvl_o))) == '0)
               && ((($past(pend_i) >> lvl_o) & LEVELS'(1)) != '0))); // R5

  AST_SLOT_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_o |-> (save_addr_o == vec_addr_o + ADDR_W'(1))); // R7

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_o |-> (($countones(mode_o) == 1) && mode_o[lvl_o] && !pend_o[lvl_o])); // R9

endmodule

bind ipd_top ipd_chk #(.LEVELS(LEVELS), .ADDR_W(ADDR_W)) u_ipd_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .eval_i      (eval_i),
  .pend_i      (pend_i),
  .arm_i       (arm_i),
  .dsp_o       (dsp_o),
  .hlt_o       (hlt_o),
  .idle_o      (idle_o),
  .lvl_o       (lvl_o),
  .vec_addr_o  (vec_addr_o),
  .save_addr_o (save_addr_o),
  .pend_o      (pend_o),
  .mode_o      (mode_o)
);

// File: tb/test_ipd_top.sv
module test_ipd_top;

  localparam int L    = 4;
  localparam int AW   = 6;
  localparam int BASE = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          eval_i;
  logic [L-1:0]  pend_i, arm_i, mode_i;
  logic [AW-1:0] sp_i;
  logic          dsp_o, hlt_o, idle_o;
  logic [1:0]    lvl_o;
  logic [AW-1:0] vec_addr_o, save_addr_o;
  logic [L-1:0]  pend_o, mode_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ipd_top #(.LEVELS(L), .ADDR_W(AW), .TBL_BASE(AW'(BASE))) i_ipd_top (
    .clk (clk), .rst_n (rst_n), .eval_i (eval_i),
    .pend_i (pend_i), .arm_i (arm_i), .mode_i (mode_i), .sp_i (sp_i),
    .dsp_o (dsp_o), .hlt_o (hlt_o), .idle_o (idle_o), .lvl_o (lvl_o),
    .vec_addr_o (vec_addr_o), .save_addr_o (save_addr_o),
    .pend_o (pend_o), .mode_o (mode_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (pend=%0d arm=%0d mode=%0d sp=%0d)",
               req, act, exp, pend_i, arm_i, mode_i, sp_i);
    end
  endtask

  function automatic int sgn4(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  // model state for held outputs
  int e_lvl = 0, e_vec = 0, e_sav = 0, e_pend = 0, e_mode = 0, e_idle = 0;

  task automatic run_one(input int p, input int a, input int m, input int s);
    int  cand;
    bit  go, halt, idle;
    cand = -1;
    for (int b = 0; b < L; b++) if (cand < 0 && ((p >> b) & 1) == 1) cand = b;
    idle = (p == 0);
    go   = !idle;
    if (go && ((a >> 3) & 1) == 0) go = 0;                                   // R3
    if (go && (m & 7) != 0 && sgn4(m) <= sgn4(p)) go = 0;                    // R4
    if (go && ((a >> cand) & 1) == 0) go = 0;                                // R6
    halt = go && (s <= 0);                                                   // R8
    if (halt) go = 0;
    e_idle = idle;
    if (!halt) begin
      e_pend = p;
      e_mode = m;
    end
    if (go) begin
      e_lvl  = cand;                                                         // R5
      e_vec  = BASE + 2 * cand;                                              // R7
      e_sav  = BASE + 2 * cand + 1;
      e_pend = p & ~(1 << cand);                                             // R9
      e_mode = 1 << cand;
    end
    @(negedge clk);
    pend_i = L'(p); arm_i = L'(a); mode_i = L'(m); sp_i = AW'(s);
    eval_i = 1'b1;
    @(negedge clk);
    eval_i = 1'b0;
    chk("R2 idle", int'(idle_o), int'(idle));
    chk("R3/R4/R6 dispatch", int'(dsp_o), int'(go));
    chk("R8 halt", int'(hlt_o), int'(halt));
    chk("R5 level", int'(lvl_o), e_lvl);
    chk("R7 vector", int'(vec_addr_o), e_vec);
    chk("R7 save", int'(save_addr_o), e_sav);
    chk("R9 pending", int'(pend_o), e_pend);
    chk("R9 mode", int'(mode_o), e_mode);
    // no strobe, disturbed inputs: everything holds
    pend_i = ~pend_i; arm_i = 4'hF; mode_i = 4'h0; sp_i = AW'(3);
    @(negedge clk);
    chk("R10 no dsp", int'(dsp_o), 0);
    chk("R10 no hlt", int'(hlt_o), 0);
    chk("R10 hold vec", int'(vec_addr_o), e_vec);
    chk("R10 hold pend", int'(pend_o), e_pend);
    chk("R10 hold mode", int'(mode_o), e_mode);
    chk("R10 hold idle", int'(idle_o), int'(e_idle));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int sps[3];
    sps[0] = 5; sps[1] = 0; sps[2] = -32;
    rst_n = 1'b0; eval_i = 1'b0;
    pend_i = '0; arm_i = '0; mode_i = '0; sp_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 dsp", int'(dsp_o), 0);
    chk("R1 hlt", int'(hlt_o), 0);
    chk("R1 idle", int'(idle_o), 0);
    chk("R1 lvl", int'(lvl_o), 0);
    chk("R1 vec", int'(vec_addr_o), 0);
    chk("R1 save", int'(save_addr_o), 0);
    chk("R1 pend", int'(pend_o), 0);
    chk("R1 mode", int'(mode_o), 0);
    for (int si = 0; si < 3; si++)
      for (int p = 0; p < 16; p++)
        for (int a = 0; a < 16; a++)
          for (int m = 0; m < 16; m++)
            run_one(p, a, m, sps[si]);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule